// File: doc/BRIEF.md
# Dual-Mode DAC Code Interface

This block holds the code word that sets the output level of a digitally programmed current DAC, and offers two ways to change it. In serial mode a frame is opened by pulling the active-low select low. Data is taken most significant bit first on each rising shift-clock edge. The select rising again commits the last eight bits taken as the new code. While a frame is open, the code that was in force before it leaves on the serial output, so several parts can be chained, each one's output feeding the next one's input. In pulse mode every rising shift-clock edge moves the code one step. The step is always upward (increment-only) or set by the data pin (up/down).

The pins are asynchronous to the block clock. They pass through a synchronizer and are edge-detected in the clock domain. The starting mode is taken from the synchronized levels of the select and data pins once the synchronizer has filled after reset. Later pin activity can only move the mode from pulse to serial, or from increment-only to up/down. Only a reset undoes such a move. A shutdown input freezes the code and forces the level output to zero. The held code reappears on the level output when shutdown is released.

Top module: `dac_code_if`

## Requirements
- R1: During and after reset the code and level outputs are 0 and the serial output enable is low.
- R2: The start mode is read from the synchronized pins once the synchronizer has filled after reset. Select low gives serial mode. Select high with data high gives increment-only pulse mode. Select high with data low gives up/down pulse mode.
- R3: In serial mode data is shifted in on rising shift-clock edges while select is low, most significant bit first. A rising select edge makes the last eight bits shifted in the new code, so the first of those bits lands in code bit 7.
- R4: On a falling select edge the serial output shows bit 7 of the code held before the frame. After the k-th falling shift-clock edge (k = 1..7) it shows bit 7-k of that code. After the eighth it shows the first bit received in the frame.
- R5: The serial output enable is high only in serial mode while select is low. It is low at all times in pulse mode.
- R6: In increment-only mode each rising shift-clock edge raises the code by one.
- R7: In increment-only mode a low data pin switches to up/down mode, which lasts until reset. In up/down mode each rising shift-clock edge raises the code by one when data is high and lowers it by one when data is low.
- R8: In pulse mode the code saturates at 255 going up and at 0 going down and never wraps.
- R9: A falling select edge in pulse mode switches to serial mode, which lasts until reset. Shift-clock edges with select high then leave the code unchanged.
- R10: While shutdown is high, pulse steps and serial loads leave the code unchanged and the level output reads 0. On release, the level output shows the held code again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Shift/step clock pin (asynchronous) |
| csn_i | input | 1 | Active-low select pin (asynchronous) |
| dio_i | input | 1 | Serial data in, or up/down control in pulse mode |
| shdn_i | input | 1 | Shutdown, active high |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Serial data out enable; low means high-impedance |
| code_o | output | 8 | Held code register |
| level_o | output | 8 | Code presented to the DAC; zero in shutdown |

## Verification
On every cycle, the assertions check that the output enable only rises in serial mode. They also check that the serial and up/down modes never revert without a reset, that a pulse step moves the code by at most one and never wraps at either end, and that the code stays frozen throughout shutdown. The bench scenarios show the rest. These are the start-mode choice from the pin levels at reset, the bit order of the shifted-out old code and of the committed new one, and the keep-the-last-eight-bits rule on long frames. They also include the increment-only to up/down switch under random direction patterns, and the restored level after shutdown.

// File: rtl/dac_code_pkg.sv
package dac_code_pkg;

    typedef enum logic [1:0] {
        MODE_BOOT   = 2'd0,
        MODE_SERIAL = 2'd1,
        MODE_INC    = 2'd2,
        MODE_UPDN   = 2'd3
    } dac_mode_e;

    typedef struct packed {
        logic sclk;
        logic csn;
        logic dio;
        logic shdn;
    } pin_vec_s;

    localparam int PIN_COUNT = $bits(pin_vec_s);

    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic csn_rise;
        logic csn_fall;
    } pin_edge_s;

    function automatic logic is_pulse_mode(input dac_mode_e m);
        return (m == MODE_INC) || (m == MODE_UPDN);
    endfunction

endpackage

// File: rtl/dac_pin_sampler.sv
module dac_pin_sampler
    import dac_code_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  pin_vec_s  pins_async,
    output pin_vec_s  pins_sync,
    output pin_edge_s edges,
    output logic      ready
);
    localparam int FILL_LIMIT = SYNC_STAGES + 1;
    localparam int FILL_W     = $clog2(FILL_LIMIT + 1);

    logic [PIN_COUNT-1:0] raw_vec;
    logic [PIN_COUNT-1:0] sync_vec;
    logic [PIN_COUNT-1:0] prev_vec;
    logic [FILL_W-1:0]    fill_cnt;
    pin_vec_s             cur;
    pin_vec_s             prv;

    assign raw_vec = pins_async;

    genvar g;
    generate
        for (g = 0; g < PIN_COUNT; g++) begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[SYNC_STAGES-2:0], raw_vec[g]};
                end
            end
            assign sync_vec[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_vec <= '0;
            fill_cnt <= '0;
        end else begin
            prev_vec <= sync_vec;
            if (fill_cnt != FILL_W'(FILL_LIMIT)) begin
                fill_cnt <= fill_cnt + 1'b1;
            end
        end
    end

    assign ready = (fill_cnt == FILL_W'(FILL_LIMIT));
    assign cur   = sync_vec;
    assign prv   = prev_vec;

    always_comb begin
        pins_sync       = cur;
        edges.sclk_rise = ready &&  cur.sclk && !prv.sclk;
        edges.sclk_fall = ready && !cur.sclk &&  prv.sclk;
        edges.csn_rise  = ready &&  cur.csn  && !prv.csn;
        edges.csn_fall  = ready && !cur.csn  &&  prv.csn;
    end

endmodule

// File: rtl/dac_mode_ctrl.sv
module dac_mode_ctrl
    import dac_code_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ready,
    input  pin_vec_s  pins,
    input  pin_edge_s edges,
    output dac_mode_e mode
);
    dac_mode_e mode_q;
    dac_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_BOOT: begin
                if (ready) begin
                    if (!pins.csn)     mode_d = MODE_SERIAL;
                    else if (pins.dio) mode_d = MODE_INC;
                    else               mode_d = MODE_UPDN;
                end
            end
            MODE_INC: begin
                if (edges.csn_fall)  mode_d = MODE_SERIAL;
                else if (!pins.dio)  mode_d = MODE_UPDN;
            end
            MODE_UPDN: begin
                if (edges.csn_fall)  mode_d = MODE_SERIAL;
            end
            MODE_SERIAL: begin
                mode_d = MODE_SERIAL;
            end
            default: mode_d = MODE_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_BOOT;
        else     mode_q <= mode_d;
    end

    assign mode = mode_q;

endmodule

// File: rtl/dac_shift_port.sv
module dac_shift_port
    import dac_code_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_vec_s          pins,
    input  pin_edge_s         edges,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] word,
    output logic              sdo
);
    logic [CODE_W-1:0] shreg;
    logic              out_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            out_bit <= 1'b0;
        end else if (edges.csn_fall) begin
            shreg   <= code;
            out_bit <= code[CODE_W-1];
        end else if (!pins.csn) begin
            if (edges.sclk_rise) begin
                shreg <= {shreg[CODE_W-2:0], pins.dio};
            end
            if (edges.sclk_fall) begin
                out_bit <= shreg[CODE_W-1];
            end
        end
    end

    assign word = shreg;
    assign sdo  = out_bit;

endmodule

// File: rtl/dac_code_reg.sv
module dac_code_reg
    import dac_code_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  dac_mode_e         mode,
    input  pin_vec_s          pins,
    input  pin_edge_s         edges,
    input  logic [CODE_W-1:0] word,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;

    logic [CODE_W-1:0] code_q;
    logic              do_load;
    logic              do_step;
    logic              step_up;

    function automatic logic [CODE_W-1:0] sat_step(
        input logic [CODE_W-1:0] cur,
        input logic              up
    );
        if (up) return (cur == CODE_MAX) ? cur : cur + 1'b1;
        else    return (cur == CODE_MIN) ? cur : cur - 1'b1;
    endfunction

    assign do_load = (mode == MODE_SERIAL) && edges.csn_rise && !pins.shdn;
    assign do_step = is_pulse_mode(mode) && pins.csn && edges.sclk_rise && !pins.shdn;
    assign step_up = (mode == MODE_INC) || pins.dio;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (do_load) begin
            code_q <= word;
        end else if (do_step) begin
            code_q <= sat_step(code_q, step_up);
        end
    end

    assign code = code_q;

endmodule

// File: rtl/dac_code_if.sv
module dac_code_if
    import dac_code_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              dio_i,
    input  logic              shdn_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [CODE_W-1:0] code_o,
    output logic [CODE_W-1:0] level_o
);
    pin_vec_s          pins_raw;
    pin_vec_s          pins_s;
    pin_edge_s         edges;
    logic              ready;
    dac_mode_e         mode;
    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] word;
    logic              sdo;

    always_comb begin
        pins_raw.sclk = sclk_i;
        pins_raw.csn  = csn_i;
        pins_raw.dio  = dio_i;
        pins_raw.shdn = shdn_i;
    end

    dac_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .pins_async (pins_raw),
        .pins_sync  (pins_s),
        .edges      (edges),
        .ready      (ready)
    );

    dac_mode_ctrl u_mode (
        .clk   (clk),
        .rst   (rst),
        .ready (ready),
        .pins  (pins_s),
        .edges (edges),
        .mode  (mode)
    );

    dac_shift_port #(.CODE_W(CODE_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .pins  (pins_s),
        .edges (edges),
        .code  (code),
        .word  (word),
        .sdo   (sdo)
    );

    dac_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .pins  (pins_s),
        .edges (edges),
        .word  (word),
        .code  (code)
    );

    assign sdo_oe_o = (mode == MODE_SERIAL) && !pins_s.csn;
    assign sdo_o    = sdo;
    assign code_o   = code;
    assign level_o  = pins_s.shdn ? '0 : code;

endmodule

// File: rtl/dac_code_if_chk.sv
module dac_code_if_chk
    import dac_code_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input dac_mode_e         mode,
    input logic              sdo_oe_o,
    input logic              shdn_s,
    input logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] TOP = '1;

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code_o == '0));

    a_r5_oe_serial_only: assert property (@(posedge clk) disable iff (rst)
        sdo_oe_o |-> (mode == MODE_SERIAL));

    a_r9_serial_sticky: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SERIAL) |=> (mode == MODE_SERIAL));

    a_r7_updn_sticky: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_UPDN) |=> (mode == MODE_UPDN || mode == MODE_SERIAL));

    a_r6_inc_step: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_INC) |=> (code_o == $past(code_o) || code_o == $past(code_o) + 1'b1));

    a_r8_no_wrap_high: assert property (@(posedge clk) disable iff (rst)
        (is_pulse_mode(mode) && code_o == TOP) |=> (code_o != '0));

    a_r8_no_wrap_low: assert property (@(posedge clk) disable iff (rst)
        (is_pulse_mode(mode) && code_o == '0) |=> (code_o != TOP));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        shdn_s |=> $stable(code_o));

endmodule

bind dac_code_if dac_code_if_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .sdo_oe_o (sdo_oe_o),
    .shdn_s   (pins_s.shdn),
    .code_o   (code_o)
);

// File: tb/tb_dac_code_if.sv
module tb_dac_code_if;
    logic       clk = 1'b0;
    logic       rst;
    logic       sclk, csn, dio, shdn;
    logic       sdo, sdo_oe;
    logic [7:0] code, level;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [7:0] exp_code;
    logic       mode_updn;

    always #4 clk = ~clk;

    dac_code_if dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .csn_i(csn), .dio_i(dio),
        .shdn_i(shdn), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .code_o(code), .level_o(level)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic c, input logic d);
        @(negedge clk);
        rst = 1'b1; csn = c; dio = d; sclk = 1'b0; shdn = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        exp_code = 8'd0;
    endtask

    function automatic logic [7:0] model_step(input logic [7:0] c, input logic up);
        if (up) return (c == 8'hFF) ? c : c + 8'd1;
        else    return (c == 8'h00) ? c : c - 8'd1;
    endfunction

    task automatic pulse(input logic d);
        dio = d; settle();
        sclk = 1'b1; settle();
        sclk = 1'b0; settle();
    endtask

    task automatic frame(input logic [7:0] b, input int nbits, input logic held);
        logic [7:0] old = code;
        logic [15:0] sent = 16'd0;
        csn = 1'b0; settle();
        chk("R5 oe in frame", int'(sdo_oe), 1);
        chk("R4 first bit", int'(sdo), int'(old[7]));
        for (int k = 1; k <= nbits; k++) begin
            logic bitv = (nbits == 8) ? b[8-k] : logic'($urandom_range(0, 1));
            sent = {sent[14:0], bitv};
            dio = bitv; settle();
            sclk = 1'b1; settle();
            sclk = 1'b0; settle();
            if (k < 8)       chk("R4 old bit", int'(sdo), int'(old[7-k]));
            else if (k == 8) chk("R4 chained bit", int'(sdo), int'(sent[7]));
        end
        csn = 1'b1; settle();
        chk("R5 oe after frame", int'(sdo_oe), 0);
        if (!held) exp_code = sent[7:0];
        chk("R3 commit", int'(code), int'(exp_code));
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; sclk = 1'b0; csn = 1'b1; dio = 1'b1; shdn = 1'b0;

        // R1, R2: increment-only start
        do_reset(1'b1, 1'b1);
        chk("R1 code", int'(code), 0);
        chk("R1 level", int'(level), 0);
        chk("R1 oe", int'(sdo_oe), 0);
        for (int i = 0; i < 3; i++) pulse(1'b1);
        chk("R6 three steps", int'(code), 3);
        chk("R5 oe pulse mode", int'(sdo_oe), 0);
        for (int i = 0; i < 255; i++) pulse(1'b1);
        chk("R8 saturate high", int'(code), 255);
        exp_code = 8'd255;

        // R7: switch to up/down by a low data level, then random steps
        pulse(1'b0);
        exp_code = 8'd254;
        chk("R7 first down", int'(code), int'(exp_code));
        for (int i = 0; i < 150; i++) begin
            logic d = logic'($urandom_range(0, 1));
            pulse(d);
            exp_code = model_step(exp_code, d);
            chk("R7 random step", int'(code), int'(exp_code));
        end
        while (exp_code != 8'd0) begin
            pulse(1'b0);
            exp_code = model_step(exp_code, 1'b0);
        end
        pulse(1'b0); pulse(1'b0);
        chk("R8 saturate low", int'(code), 0);
        for (int i = 0; i < 5; i++) pulse(1'b1);
        exp_code = 8'd5;
        chk("R7 up again", int'(code), 5);

        // R10: shutdown
        shdn = 1'b1; settle();
        chk("R10 level zero", int'(level), 0);
        pulse(1'b1); pulse(1'b0);
        chk("R10 code held", int'(code), 5);
        shdn = 1'b0; settle();
        chk("R10 level restored", int'(level), 5);

        // R9: falling select moves to serial
        frame(8'hA5, 8, 1'b0);
        chk("R9 serial load", int'(code), 8'hA5);
        pulse(1'b1); pulse(1'b0);
        chk("R9 no step in serial", int'(code), 8'hA5);
        for (int i = 0; i < 20; i++) frame(8'($urandom_range(0, 255)), 8, 1'b0);
        frame(8'h00, 11, 1'b0);
        frame(8'h81, 8, 1'b0);
        chk("R3 msb first", int'(code), 8'h81);
        shdn = 1'b1; settle();
        frame(8'h3C, 8, 1'b1);
        chk("R10 serial ignored", int'(code), 8'h81);
        shdn = 1'b0; settle();
        chk("R10 level after serial", int'(level), 8'h81);

        // R2: serial start
        do_reset(1'b0, 1'b1);
        chk("R2 serial start oe", int'(sdo_oe), 1);
        chk("R1 code serial start", int'(code), 0);
        csn = 1'b1; settle();
        pulse(1'b1);
        chk("R2 serial start no step", int'(code), 0);

        // R2: up/down start
        do_reset(1'b1, 1'b0);
        pulse(1'b0);
        chk("R2 updn start floor", int'(code), 0);
        pulse(1'b1); pulse(1'b1); pulse(1'b0);
        chk("R2 updn start steps", int'(code), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule